// File: doc/BRIEF.md
# Nanosecond Alarm Timer

This block is a timer peripheral on a 32-bit register bus. It keeps a 64-bit count of nanoseconds since reset. The count grows by a fixed, parameterised number of nanoseconds on every clock. Software reads the count as two 32-bit words. Reading the low word also latches the upper word, so the pair never tears when the count carries between the two reads.

Software sets a 64-bit alarm in two steps. It first stages the upper half, then writes the lower half, which commits the alarm. If the committed alarm is not in the future, the interrupt rises at once and nothing is armed. Otherwise the alarm is armed and fires on the first clock at which the count has reached or passed it. The interrupt is a level. It stays high until software clears it, either alone or together with any armed alarm. The block decodes a 4 KiB window. Read data is registered and appears in the cycle after the read strobe.

Top module: `ns_alarm_timer`

## Requirements
- R1: After a cycle with `rst_n` low, the count, the latched upper word, the staged and committed alarm and the armed flag are all zero, and `irq` and `rdata` are low.
- R2: Each clock with `rst_n` high adds `NS_PER_CLK` to the count, modulo 2^64.
- R3: A read at offset 0x00 returns, in the next cycle, the low 32 bits of the count as it stood in the read cycle, and latches the upper 32 bits of that same count.
- R4: A read at offset 0x04 returns the upper word latched by the most recent 0x00 read, not the live upper bits.
- R5: A write at offset 0x0C only stages the upper alarm half. It arms nothing and fires nothing, and it does not change when an alarm that is already armed fires. The staged value is used by the next 0x08 write.
- R6: A write at offset 0x08 commits {staged upper, write data} as the alarm. If that value is at or below the count in the write cycle, `irq` is high from the next cycle and the alarm stays unarmed. Otherwise the alarm is armed.
- R7: An armed alarm fires on the first clock at which count >= alarm. Firing clears the armed flag and raises `irq` in the following cycle.
- R8: Once high, `irq` stays high until a write at 0x10 or 0x14 clears it.
- R9: A write at offset 0x10 lowers `irq` and leaves the armed state unchanged.
- R10: A write at offset 0x14 disarms any armed alarm and lowers `irq`.
- R11: Reads at any offset other than 0x00 and 0x04 return zero, including the alarm and clear offsets. `rdata` is zero after a cycle without a read. Writes at offsets other than 0x08, 0x0C, 0x10 and 0x14 change nothing.
- R12: If a 0x10 write falls in the cycle in which an alarm fires, `irq` is high afterwards. If a 0x14 write falls in the cycle of a match, the alarm does not fire and `irq` is low afterwards.
- R13: If a 0x08 write falls in the cycle in which the armed alarm matches, the old alarm does not fire. The new value alone decides whether the block fires at once or re-arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (12) | Byte offset within the window |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
Two events can fall on the same clock: a register write, and the firing of an armed alarm. The bench arms an alarm with a known offset from the count, so it knows the exact edge of the match. It then places a clear-interrupt write, a clear-alarm write or a new alarm-low write on that edge. It judges each case from `irq` one cycle later and over the following cycles. A re-armed alarm must fire at its new time and not at the old one.

// File: rtl/ns_timer_pkg.sv
// Shared constants and types for the nanosecond alarm timer.
// Offsets are byte offsets within the decoded window.
package ns_timer_pkg;
    localparam int unsigned OFS_TIME_LO   = 'h00;
    localparam int unsigned OFS_TIME_HI   = 'h04;
    localparam int unsigned OFS_ALARM_LO  = 'h08;
    localparam int unsigned OFS_ALARM_HI  = 'h0C;
    localparam int unsigned OFS_CLR_IRQ   = 'h10;
    localparam int unsigned OFS_CLR_ALARM = 'h14;

    // Which readable word a read access selects.
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_LO   = 2'd1,
        RSEL_HI   = 2'd2
    } rsel_e;

    // One strobe per writable register.
    typedef struct packed {
        logic alarm_lo;
        logic alarm_hi;
        logic clr_irq;
        logic clr_alarm;
    } wstb_t;
endpackage

// File: rtl/ns_bus_decode.sv
// Address decoder: turns the read and write strobes into per-register
// selects. It is purely combinational. It assumes at most one access per
// cycle, and any offset it does not recognise selects nothing.
module ns_bus_decode
    import ns_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output wstb_t             wstb,
    output rsel_e             rsel
);
    // Match the offset against each mapped register.
    always_comb begin
        wstb = '0;
        rsel = RSEL_NONE;
        if (wr_en) begin
            wstb.alarm_lo  = (addr == ADDR_W'(OFS_ALARM_LO));
            wstb.alarm_hi  = (addr == ADDR_W'(OFS_ALARM_HI));
            wstb.clr_irq   = (addr == ADDR_W'(OFS_CLR_IRQ));
            wstb.clr_alarm = (addr == ADDR_W'(OFS_CLR_ALARM));
        end
        if (rd_en) begin
            if (addr == ADDR_W'(OFS_TIME_LO))
                rsel = RSEL_LO;
            else if (addr == ADDR_W'(OFS_TIME_HI))
                rsel = RSEL_HI;
        end
    end
endmodule

// File: rtl/ns_tick_counter.sv
// Free-running nanosecond counter. It adds STEP on every clock outside
// reset and wraps modulo 2^CNT_W. It assumes STEP fits in CNT_W bits.
module ns_tick_counter #(
    parameter int              CNT_W = 64,
    parameter longint unsigned STEP  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    // Advance the count by one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(STEP);
    end
endmodule

// File: rtl/ns_read_latch.sv
// Read path. A low-word read returns the live low half and keeps the live
// upper half. A high-word read returns the kept half. The low half goes
// straight to rdata, so only the upper half needs storage. Read data is
// registered and is zero after any cycle that reads nothing mapped.
module ns_read_latch
    import ns_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rsel_e               rsel,
    input  logic [2*DATA_W-1:0] cnt,
    output logic [DATA_W-1:0]   rdata
);
    logic [DATA_W-1:0] snap_hi;

    // Latch the upper half on low reads and drive the read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hi <= '0;
            rdata   <= '0;
        end else begin
            case (rsel)
                RSEL_LO: begin
                    rdata   <= cnt[DATA_W-1:0];
                    snap_hi <= cnt[2*DATA_W-1:DATA_W];
                end
                RSEL_HI: rdata <= snap_hi;
                default: rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ns_alarm_unit.sv
// Alarm state: a staged upper half, the committed 64-bit alarm, the armed
// flag and the level interrupt. Commit and clear writes take priority over
// a match in the same cycle. A firing wins over a clear-interrupt write in
// the same cycle. It assumes at most one write strobe per cycle.
module ns_alarm_unit
    import ns_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wstb_t               wstb,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] cnt,
    output logic [DATA_W-1:0]   alarm_stage,
    output logic [2*DATA_W-1:0] alarm,
    output logic                armed,
    output logic                irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] candidate;
    logic             commit_due;
    logic             hit;
    logic             fire;

    // Work out whether to fire: a commit that is already due, or a match.
    always_comb begin
        candidate  = {alarm_stage, wdata};
        commit_due = wstb.alarm_lo && (candidate <= cnt);
        hit        = armed && (cnt >= alarm) && !wstb.alarm_lo && !wstb.clr_alarm;
        fire       = commit_due || hit;
    end

    // Hold the staged upper half and the committed alarm value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_stage <= '0;
            alarm       <= '0;
        end else begin
            if (wstb.alarm_hi)
                alarm_stage <= wdata;
            if (wstb.alarm_lo)
                alarm <= candidate;
        end
    end

    // Set or clear the armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (wstb.alarm_lo)
            armed <= !commit_due;
        else if (wstb.clr_alarm || hit)
            armed <= 1'b0;
    end

    // Hold the interrupt level; a firing beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (fire)
            irq <= 1'b1;
        else if (wstb.clr_irq || wstb.clr_alarm)
            irq <= 1'b0;
    end
endmodule

// File: rtl/ns_alarm_timer.sv
// Top of the nanosecond alarm timer. It wires the decoder, the counter,
// the read path and the alarm unit together. It assumes one bus access per
// cycle and DATA_W-bit halves of a 2*DATA_W-bit count.
module ns_alarm_timer
    import ns_timer_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter int              DATA_W     = 32,
    parameter longint unsigned NS_PER_CLK = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    wstb_t             wstb;
    rsel_e             rsel;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] alarm_stage_w;
    logic [CNT_W-1:0]  alarm_w;
    logic              armed_w;

    ns_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wstb  (wstb),
        .rsel  (rsel)
    );

    ns_tick_counter #(.CNT_W(CNT_W), .STEP(NS_PER_CLK)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_w)
    );

    ns_read_latch #(.DATA_W(DATA_W)) u_read (
        .clk   (clk),
        .rst_n (rst_n),
        .rsel  (rsel),
        .cnt   (cnt_w),
        .rdata (rdata)
    );

    ns_alarm_unit #(.DATA_W(DATA_W)) u_alarm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wstb        (wstb),
        .wdata       (wdata),
        .cnt         (cnt_w),
        .alarm_stage (alarm_stage_w),
        .alarm       (alarm_w),
        .armed       (armed_w),
        .irq         (irq)
    );
endmodule

// File: rtl/ns_alarm_timer_chk.sv
// Property checker for the nanosecond alarm timer. It watches the ports
// and the count and alarm state, and is bound into every instance of the top.
module ns_alarm_timer_chk
    import ns_timer_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter int              DATA_W     = 32,
    parameter longint unsigned NS_PER_CLK = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [DATA_W-1:0]   wdata,
    input logic [DATA_W-1:0]   rdata,
    input logic                irq,
    input logic [2*DATA_W-1:0] cnt,
    input logic [DATA_W-1:0]   alarm_stage,
    input logic [2*DATA_W-1:0] alarm,
    input logic                armed
);
    localparam int CNT_W = 2 * DATA_W;

    logic wr_alo, wr_ahi, wr_cli, wr_cla, rd_time;
    assign wr_alo  = wr_en && (addr == ADDR_W'(OFS_ALARM_LO));
    assign wr_ahi  = wr_en && (addr == ADDR_W'(OFS_ALARM_HI));
    assign wr_cli  = wr_en && (addr == ADDR_W'(OFS_CLR_IRQ));
    assign wr_cla  = wr_en && (addr == ADDR_W'(OFS_CLR_ALARM));
    assign rd_time = rd_en && ((addr == ADDR_W'(OFS_TIME_LO)) || (addr == ADDR_W'(OFS_TIME_HI)));

    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + CNT_W'(NS_PER_CLK));

    a_r5_stage_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ahi && !armed) |=> !armed);

    a_r6_due_commit_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_alo && ({alarm_stage, wdata} <= cnt)) |=> (irq && !armed));

    a_r7_armed_match_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && armed && (cnt >= alarm)) |=> (irq && !armed));

    a_r8_irq_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_cli && !wr_cla) |=> irq);

    a_r9_clr_irq_keeps_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cli && armed && (cnt < alarm)) |=> (armed && !irq));

    a_r10_clr_alarm_drops: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cla |=> (!armed && !irq));

    a_r11_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_time |=> (rdata == '0));

    a_r12_fire_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cli && armed && (cnt >= alarm)) |=> irq);
endmodule

bind ns_alarm_timer ns_alarm_timer_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NS_PER_CLK (NS_PER_CLK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq         (irq),
    .cnt         (cnt_w),
    .alarm_stage (alarm_stage_w),
    .alarm       (alarm_w),
    .armed       (armed_w)
);

// File: tb/ns_alarm_timer_tb.sv
// Scoreboard bench: the read task queues each expected word, and a monitor
// pops it and compares it with rdata one edge later. Interrupt checks are
// made at falling edges, against edge counts worked out from the arm time.
module ns_alarm_timer_tb;
    localparam longint unsigned INC = 64'h1000_0000;
    localparam logic [11:0] A_TLO = 12'h000, A_THI = 12'h004, A_ALO = 12'h008,
                            A_AHI = 12'h00C, A_CLI = 12'h010, A_CLA = 12'h014;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    logic [63:0] model;
    logic [31:0] snap_hi_m;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    ns_alarm_timer #(.ADDR_W(12), .DATA_W(32), .NS_PER_CLK(INC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    // Reference count, taken from R1 and R2.
    always @(posedge clk) model <= !rst_n ? 64'd0 : model + INC;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: after each read strobe, compare rdata with the queued word.
    always @(posedge clk) begin
        if (rd_en) begin
            #5;
            if (exp_q.size() == 0) chk("R3 monitor underflow", 64'd1, 64'd0);
            else chk(tag_q.pop_front(), {32'd0, rdata}, {32'd0, exp_q.pop_front()});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0; addr = '0;
    endtask

    task automatic rd_lo(input string tag);
        snap_hi_m = model[63:32];
        rd(A_TLO, model[31:0], tag);
    endtask

    // Stage and commit an alarm of k steps plus off past the count at commit.
    task automatic arm(input int k, input logic [31:0] off, output logic [63:0] t);
        t = model + INC + 64'(k) * INC + 64'(off);
        wr(A_AHI, t[63:32]);
        wr(A_ALO, t[31:0]);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] t;
        logic [63:0] first;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {63'd0, irq}, 64'd0);
        chk("R1 rdata in reset", {32'd0, rdata}, 64'd0);
        rst_n = 1'b1;
        rd(A_THI, 32'd0, "R1 latched upper word after reset");
        chk("R1 irq after reset", {63'd0, irq}, 64'd0);

        // R2 and R3: low reads follow the count.
        first = model;
        rd_lo("R3 first low read");
        repeat (3) @(negedge clk);
        t = first + 4 * INC;
        rd_lo("R3 second low read");
        chk("R2 step of four clocks", model - 64'(INC), t);

        // R4: the high word comes from the snapshot.
        repeat (20) @(negedge clk);
        rd_lo("R4 low read before carry");
        repeat (20) @(negedge clk);
        chk("R4 live upper moved", {63'd0, model[63:32] != snap_hi_m}, 64'd1);
        rd(A_THI, snap_hi_m, "R4 latched upper word");

        // R5: staging the upper half alone does nothing.
        wr(A_AHI, 32'd0);
        repeat (10) @(negedge clk);
        chk("R5 stage only no irq", {63'd0, irq}, 64'd0);

        // R6: an alarm equal to the count fires at once; R8 it holds; R9 clear.
        t = model + INC;
        wr(A_AHI, t[63:32]);
        wr(A_ALO, t[31:0]);
        chk("R6 equal alarm fires", {63'd0, irq}, 64'd1);
        repeat (3) @(negedge clk);
        chk("R8 irq held", {63'd0, irq}, 64'd1);
        wr(A_CLI, 32'd0);
        chk("R9 clear irq", {63'd0, irq}, 64'd0);
        repeat (10) @(negedge clk);
        chk("R6 left unarmed", {63'd0, irq}, 64'd0);

        // R7: the armed alarm fires on the sixth edge after commit.
        arm(5, 32'd3, t);
        repeat (5) @(negedge clk);
        chk("R7 not before match", {63'd0, irq}, 64'd0);
        @(negedge clk);
        chk("R7 fires at count >= alarm", {63'd0, irq}, 64'd1);
        repeat (4) @(negedge clk);
        chk("R8 level stays", {63'd0, irq}, 64'd1);
        wr(A_CLA, 32'd0);
        chk("R10 clear alarm drops irq", {63'd0, irq}, 64'd0);

        // R5: restaging while armed does not move the armed alarm.
        arm(5, 32'd3, t);
        wr(A_AHI, 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        chk("R5 armed not early", {63'd0, irq}, 64'd0);
        @(negedge clk);
        chk("R5 armed alarm unchanged by stage", {63'd0, irq}, 64'd1);
        wr(A_CLA, 32'd0);

        // R9: clearing the interrupt keeps the alarm armed.
        arm(5, 32'd3, t);
        wr(A_CLI, 32'd0);
        repeat (4) @(negedge clk);
        chk("R9 still quiet", {63'd0, irq}, 64'd0);
        @(negedge clk);
        chk("R9 stays armed and fires", {63'd0, irq}, 64'd1);
        wr(A_CLA, 32'd0);

        // R10: clearing the alarm disarms it.
        arm(5, 32'd3, t);
        wr(A_CLA, 32'd0);
        repeat (10) @(negedge clk);
        chk("R10 disarmed never fires", {63'd0, irq}, 64'd0);

        // R11: other offsets read zero; stray writes do nothing.
        rd(12'h018, 32'd0, "R11 unmapped read");
        rd(A_ALO, 32'd0, "R11 alarm offset reads zero");
        rd(A_CLI, 32'd0, "R11 clear offset reads zero");
        wr(12'h018, 32'h1234_5678);
        wr(A_TLO, 32'hDEAD_BEEF);
        wr(12'h80C, 32'd0);
        chk("R11 stray writes no irq", {63'd0, irq}, 64'd0);
        rd_lo("R11 count unaffected");
        @(negedge clk);
        chk("R11 rdata idle zero", {32'd0, rdata}, 64'd0);

        // R12: a clear-interrupt write on the firing edge loses.
        arm(5, 32'd3, t);
        repeat (5) @(negedge clk);
        wr(A_CLI, 32'd0);
        chk("R12 fire beats clear irq", {63'd0, irq}, 64'd1);
        wr(A_CLI, 32'd0);

        // R12: a clear-alarm write on the match edge wins.
        arm(5, 32'd3, t);
        repeat (5) @(negedge clk);
        wr(A_CLA, 32'd0);
        chk("R12 clear alarm on match", {63'd0, irq}, 64'd0);
        repeat (10) @(negedge clk);
        chk("R12 no late firing", {63'd0, irq}, 64'd0);

        // R13: an alarm-low write on the match edge re-arms instead.
        while (model[31:0] != 32'd0) @(negedge clk);
        arm(5, 32'd3, t);
        repeat (5) @(negedge clk);
        t = model + 8 * INC;
        wr(A_ALO, t[31:0]);
        chk("R13 old match dropped", {63'd0, irq}, 64'd0);
        repeat (7) @(negedge clk);
        chk("R13 new alarm not early", {63'd0, irq}, 64'd0);
        @(negedge clk);
        chk("R13 new alarm fires", {63'd0, irq}, 64'd1);
        wr(A_CLA, 32'd0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule